// File: doc/BRIEF.md
# Product-Term AND Array with Serial Configuration

This block is the AND plane of one logic block in a sum-of-products programmable fabric. Every routed input is turned into two literals, its true form and its complement. A configuration store decides, for each product term, which literals it takes in. Each product term is the AND of the literals it takes in. Most terms feed the bus that goes on to the term allocator. The last three terms are kept out of that path and serve as the shared clock, the shared initialization (set/reset) term and the shared output enable of the logic block.

The configuration is written through a one-bit serial port. The same port reads it back: the stored bits rotate past a serial output in the order they were written. While configuration is being written or read, every term output is held low, so downstream logic never sees a half-written array. Outside those windows the term outputs depend only combinationally on the routed inputs.

Top module: `pt_and_array`

## Requirements
- R1: Literal 2i is the true form of `routedIn[i]` and literal 2i+1 is its complement. An enabled term is the AND of all literals whose select bit is 1.
- R2: An enabled term with no select bits set evaluates to 1.
- R3: A term whose disable bit is 1 outputs 0, whatever its select bits and the inputs are.
- R4: A term that selects both literals of the same input outputs 0 for every input pattern.
- R5: Terms 0 to NUM_TERMS-4 drive `logicTerms` bit for bit. Term NUM_TERMS-3 drives `shClk`, term NUM_TERMS-2 drives `shInit` and term NUM_TERMS-1 drives `shOe`.
- R6: While `loadEn` is high, one bit of `serIn` is taken in on each rising clock edge. After NUM_TERMS*(2*NUM_IN+1) such edges, the k-th bit taken in configures term k/(2*NUM_IN+1), at position k mod (2*NUM_IN+1). Positions 0 to 2*NUM_IN-1 are the literal select bits and the last position is the disable bit.
- R7: While `loadEn` is high, every term output is 0.
- R8: `serOut` shows stored bit 0 (term 0, literal 0). Each rising edge with `readEn` high and `loadEn` low advances `serOut` by one bit, in the same order the bits were loaded. After one full pass the configuration is unchanged.
- R9: While `readEn` is high, every term output is 0. When `loadEn` and `readEn` are both high, the load takes effect and the read does not.
- R10: Reset sets every stored bit to 1. After reset every term output is 0 and `serOut` is 1.
- R11: With both enables low, the configuration holds and the term outputs follow `routedIn` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Serial configuration write enable |
| serIn | input | 1 | Serial configuration data in |
| readEn | input | 1 | Serial readback advance |
| serOut | output | 1 | Serial readback data |
| routedIn | input | 36 | Routed inputs to the array |
| logicTerms | output | 80 | Logic product terms to the allocator |
| shClk | output | 1 | Shared clock product term |
| shInit | output | 1 | Shared initialization product term |
| shOe | output | 1 | Shared output-enable product term |

## Verification
The hardest situation to reach from the ports is a single term that holds a contradiction (both literals of one input), or a disable bit set on top of live selects, while its neighbours behave normally. The only way in is the full serial stream, with exactly one bit placed at the right offset. The bench builds the array small (4 inputs, 7 terms), writes a hand-built stream that puts each special case into its own term, and sweeps all 16 input patterns. It then checks every term against a sum-of-products evaluation done in the bench. It also reads the whole stream back, repeats the sweep to show that the rotation left the array unchanged, and loads pseudo-random streams, one of them with `readEn` held high during the load.

// File: rtl/pt_array_pkg.sv
package pt_array_pkg;

  // Number of product terms kept back as shared control terms
  localparam int CTRL_TERMS = 3;

  // Strobes from the configuration control to the term datapath
  typedef struct packed {
    logic shiftIn;   // take one serial bit into the configuration chain
    logic rotate;    // rotate the chain by one bit for readback
    logic blank;     // force every term output low
  } cfgStrobe_t;

endpackage

// File: rtl/pt_cfg_ctrl.sv
module pt_cfg_ctrl
  import pt_array_pkg::*;
(
  input  logic       loadEn,
  input  logic       readEn,
  output cfgStrobe_t strb
);

  // Load has priority; readback only rotates when no load is running
  always_comb begin
    strb.shiftIn = loadEn;
    strb.rotate  = readEn & ~loadEn;
    strb.blank   = loadEn | readEn;
  end

endmodule

// File: rtl/pt_term_dp.sv
module pt_term_dp
  import pt_array_pkg::*;
#(
  parameter int NUM_IN    = 36,
  parameter int NUM_TERMS = 83
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strb,
  input  logic                 serIn,
  input  logic [NUM_IN-1:0]    routedIn,
  output logic                 serOut,
  output logic [NUM_TERMS-1:0] termOut
);

  localparam int LIT_W   = 2 * NUM_IN;
  localparam int ROW_W   = LIT_W + 1;
  localparam int CHAIN_W = ROW_W * NUM_TERMS;

  // Configuration chain; bit t*ROW_W+j is select j of term t, the top bit of a row is its disable
  logic [CHAIN_W-1:0] cfgChain;
  logic [LIT_W-1:0]   literals;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgChain <= '1;
    end else if (strb.shiftIn) begin
      cfgChain <= {serIn, cfgChain[CHAIN_W-1:1]};
    end else if (strb.rotate) begin
      cfgChain <= {cfgChain[0], cfgChain[CHAIN_W-1:1]};
    end
  end

  assign serOut = cfgChain[0];

  // True and complement literal for every routed input
  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign literals[2*i]   = routedIn[i];
    assign literals[2*i+1] = ~routedIn[i];
  end

  // One wired-AND per product term
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic [ROW_W-1:0] row;
    logic             andHit;
    assign row    = cfgChain[t*ROW_W +: ROW_W];
    assign andHit = &(~row[LIT_W-1:0] | literals);
    assign termOut[t] = andHit & ~row[LIT_W] & ~strb.blank;
  end

endmodule

// File: rtl/pt_and_array.sv
module pt_and_array
  import pt_array_pkg::*;
#(
  parameter int NUM_IN    = 36,
  parameter int NUM_TERMS = 83
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            loadEn,
  input  logic                            serIn,
  input  logic                            readEn,
  output logic                            serOut,
  input  logic [NUM_IN-1:0]               routedIn,
  output logic [NUM_TERMS-CTRL_TERMS-1:0] logicTerms,
  output logic                            shClk,
  output logic                            shInit,
  output logic                            shOe
);

  localparam int LOGIC_TERMS = NUM_TERMS - CTRL_TERMS;

  cfgStrobe_t           strb;
  logic [NUM_TERMS-1:0] termOut;

  pt_cfg_ctrl u_ctrl (
    .loadEn (loadEn),
    .readEn (readEn),
    .strb   (strb)
  );

  pt_term_dp #(
    .NUM_IN    (NUM_IN),
    .NUM_TERMS (NUM_TERMS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .serIn    (serIn),
    .routedIn (routedIn),
    .serOut   (serOut),
    .termOut  (termOut)
  );

  // Fixed order of the control terms: clock, initialization, output enable
  assign logicTerms = termOut[LOGIC_TERMS-1:0];
  assign shClk      = termOut[LOGIC_TERMS];
  assign shInit     = termOut[LOGIC_TERMS+1];
  assign shOe       = termOut[LOGIC_TERMS+2];

endmodule

// File: rtl/pt_and_array_chk.sv
module pt_and_array_chk
  import pt_array_pkg::*;
#(
  parameter int NUM_IN    = 36,
  parameter int NUM_TERMS = 83
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            loadEn,
  input logic                            readEn,
  input logic                            serOut,
  input logic [NUM_IN-1:0]               routedIn,
  input logic [NUM_TERMS-CTRL_TERMS-1:0] logicTerms,
  input logic                            shClk,
  input logic                            shInit,
  input logic                            shOe
);

  AST_LOAD_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> (logicTerms == '0 && !shClk && !shInit && !shOe)); // R7

  AST_READ_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    readEn |-> (logicTerms == '0 && !shClk && !shInit && !shOe)); // R9

  AST_IDLE_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !readEn) |=> $stable(serOut)); // R11

  AST_IDLE_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !readEn) ##1 (!loadEn && !readEn && $stable(routedIn))
      |-> ($stable(logicTerms) && $stable({shClk, shInit, shOe}))); // R11

endmodule

bind pt_and_array pt_and_array_chk #(
  .NUM_IN    (NUM_IN),
  .NUM_TERMS (NUM_TERMS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadEn     (loadEn),
  .readEn     (readEn),
  .serOut     (serOut),
  .routedIn   (routedIn),
  .logicTerms (logicTerms),
  .shClk      (shClk),
  .shInit     (shInit),
  .shOe       (shOe)
);

// File: tb/test_pt_and_array.sv
`timescale 1ns/1ps
module test_pt_and_array;

  localparam int NI    = 4;
  localparam int NT    = 7;
  localparam int NL    = NT - 3;
  localparam int LIT   = 2 * NI;
  localparam int ROW   = LIT + 1;
  localparam int CHAIN = ROW * NT;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadEn = 1'b0;
  logic          serIn = 1'b0;
  logic          readEn = 1'b0;
  logic          serOut;
  logic [NI-1:0] routedIn = '0;
  logic [NL-1:0] logicTerms;
  logic          shClk, shInit, shOe;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;
  logic [CHAIN-1:0] cfgBits;
  logic [31:0]      lfsr = 32'hACE1_1234;

  always #2.5 clk = ~clk;

  pt_and_array #(.NUM_IN(NI), .NUM_TERMS(NT)) i_pt_and_array (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .serIn(serIn), .readEn(readEn),
    .serOut(serOut), .routedIn(routedIn), .logicTerms(logicTerms),
    .shClk(shClk), .shInit(shInit), .shOe(shOe)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic [NT-1:0] expTerms(input logic [CHAIN-1:0] c, input logic [NI-1:0] x);
    logic [NT-1:0] r;
    for (int t = 0; t < NT; t++) begin
      logic v;
      v = 1'b1;
      for (int j = 0; j < LIT; j++)
        if (c[t*ROW+j]) v = v & ((j % 2) ? ~x[j/2] : x[j/2]);
      if (c[t*ROW+LIT]) v = 1'b0;
      r[t] = v;
    end
    return r;
  endfunction

  task automatic checkBlank(input string req);
    check(req, "blanked outputs", |{logicTerms, shClk, shInit, shOe}, 1'b0);
  endtask

  // Sweep every input pattern; tags name the requirement each term position covers
  task automatic sweep(input string tags [NT]);
    for (int p = 0; p < (1 << NI); p++) begin
      logic [NT-1:0] e;
      routedIn = p[NI-1:0];
      #1;
      e = expTerms(cfgBits, routedIn);
      for (int t = 0; t < NL; t++)
        check(tags[t], $sformatf("logic term %0d in=%h", t, p), logicTerms[t], e[t]);
      check(tags[NL],   $sformatf("clock term in=%h", p),   shClk,  e[NL]);
      check(tags[NL+1], $sformatf("init term in=%h", p),    shInit, e[NL+1]);
      check(tags[NL+2], $sformatf("oe term in=%h", p),      shOe,   e[NL+2]);
      @(negedge clk);
    end
  endtask

  task automatic loadCfg(input logic alsoRead);
    @(negedge clk);
    loadEn = 1'b1;
    readEn = alsoRead;
    for (int k = 0; k < CHAIN; k++) begin
      serIn = cfgBits[k];
      #1;
      checkBlank("R7");
      @(negedge clk);
    end
    loadEn = 1'b0;
    readEn = 1'b0;
  endtask

  task automatic readBack();
    @(negedge clk);
    readEn = 1'b1;
    for (int k = 0; k < CHAIN; k++) begin
      #1;
      check("R8", $sformatf("readback bit %0d", k), serOut, cfgBits[k]);
      checkBlank("R9");
      @(negedge clk);
    end
    readEn = 1'b0;
  endtask

  task automatic randCfg();
    for (int k = 0; k < CHAIN; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cfgBits[k] = lfsr[0] & lfsr[1];
    end
  endtask

  initial begin
    string tagsA [NT];
    string tagsR [NT];
    tagsA = '{"R1", "R1", "R2", "R4", "R5", "R3", "R5"};
    tagsR = '{"R1", "R1", "R1", "R1", "R5", "R5", "R5"};

    // Reset state
    #12;
    rstN = 1'b1;
    @(negedge clk);
    for (int p = 0; p < (1 << NI); p += 5) begin
      routedIn = p[NI-1:0];
      #1;
      check("R10", "outputs after reset", |{logicTerms, shClk, shInit, shOe}, 1'b0);
      check("R10", "serOut after reset", serOut, 1'b1);
      @(negedge clk);
    end

    // Hand-built configuration covering each special case
    cfgBits = '0;
    cfgBits[0*ROW+0] = 1'b1;                               // term0 = in0
    cfgBits[1*ROW+1] = 1'b1; cfgBits[1*ROW+2] = 1'b1;      // term1 = ~in0 & in1
    //                                                        term2: empty -> 1
    cfgBits[3*ROW+0] = 1'b1; cfgBits[3*ROW+1] = 1'b1;      // term3: in0 & ~in0 -> 0
    cfgBits[4*ROW+6] = 1'b1;                               // clock term = in3
    cfgBits[5*ROW+4] = 1'b1; cfgBits[5*ROW+LIT] = 1'b1;    // init term disabled
    cfgBits[6*ROW+5] = 1'b1; cfgBits[6*ROW+7] = 1'b1;      // oe term = ~in2 & ~in3
    loadCfg(1'b0);
    sweep(tagsA);            // R6 ordering proven by per-term results

    readBack();
    sweep(tagsA);            // R8: configuration intact after full rotation

    // Idle cycles leave configuration alone
    repeat (10) @(negedge clk);
    sweep(tagsA);            // R11

    // Pseudo-random configurations; last one loaded with readEn also high (R9 priority)
    for (int n = 0; n < 4; n++) begin
      randCfg();
      loadCfg(n == 3);
      sweep(tagsR);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule